// File: doc/BRIEF.md
# Two-Level Shared Interrupt Hub for a Card Host

This block gathers the interrupt sources of a removable-card host controller and reduces them to a single level-high interrupt line. There are two levels. At the first level, each source event is latched into a local status register. Software clears each bit there by writing a one to it. A local enable register selects which pending bits count. When any enabled local bit is pending, the second level is set: this controller's bit in a global status register. The global register also holds a bit for a sibling storage controller, which has its own event input. A global status-enable control and a global signal-enable control must both be on before the global bits can drive the line.

The block also samples the card-side pins through a synchroniser. A card counts as inserted only while both active-low detect pins are low. Every change of that inserted state raises the card-detect source. The synchronised pin levels can be read through an interface status register. All registers are reached over a simple single-cycle register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `cfh_irq_hub`

## Requirements
- R1: After reset every status and enable register reads 0, `irq_o` is low, and the interface status register reads 0x0C while both detect pins are high. The word addresses are 0 interface status, 1 local status, 2 local enable, 3 global status, 4 global status-enable, 5 global signal-enable. Any other address reads 0.
- R2: A one-cycle pulse on `src_evt[i]` sets local status bit i at the next edge, for the implemented bits 0-3 and 8-11. Pulses on bits 4-7 leave those bits reading 0.
- R3: Writing a one to a local status bit clears it, and a zero leaves it alone. Writing back the value just read clears every pending bit.
- R4: If a source event and a clear of the same local bit fall in the same cycle, the bit stays set.
- R5: Global bit 0 is set one edge after any local bit is both pending and enabled, provided global status-enable is on. A write of one clears it. If the enabled local condition is still present at that write, the bit is set again.
- R6: Interface status bits 2 and 3 show detect pins 0 and 1, and bits 4, 5 and 6 show acknowledge, card-ready and I/O-ready. Each of these lags its pin by two edges. Each change of the inserted state (both detect pins low) sets local bit 0 on the third edge after the pin change.
- R7: A pulse on `sib_evt` sets global bit 1. A write of one to bit 1 clears it.
- R8: `irq_o` is high while any global bit is pending and both global enables are on. Clearing the signal-enable drops it.
- R9: The local enable reads back what was written, limited to the implemented bits. Both global enables read back bit 0.
- R10: While global status-enable is off, no global status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_evt | input | 12 | Local source event pulses, one per status bit |
| sib_evt | input | 1 | Sibling controller event pulse |
| cd_n | input | 2 | Active-low card detect pins |
| card_ack | input | 1 | Input acknowledge pin |
| card_rdy | input | 1 | Card ready pin |
| card_iordy | input | 1 | I/O ready pin |
| irq_o | output | 1 | Level-high interrupt line |

## Verification
The embedded properties run on every cycle. They check that a source event always survives a simultaneous clear, and that a one written to a local bit without a matching event leaves that bit clear. They also check that a set request latches into global status when status-enable is on, that a detect event coincides with a toggle of the registered inserted state and reaches local bit 0 one edge later, and that turning off signal-enable silences the line at the next edge. Other behaviours can be shown only by the bench's scenarios. These are the exact latency from a pin change to the status bit, the absence of events for partial insertion, the masking of the unimplemented bits, the write-back clearing idiom, the re-set of global bit 0 while its cause persists, and the read map.

// File: rtl/cfh_irq_pkg.sv
package cfh_irq_pkg;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 32;
    localparam int LCL_W       = 12;
    localparam int GLB_W       = 2;
    localparam int SYNC_STAGES = 2;
    localparam int PIN_W       = 5;

    // bits 4..7 of the local status are not backed by storage
    localparam logic [LCL_W-1:0] LCL_IMPL = 12'hF0F;

    // interface status: position of the lowest synchronised pin
    localparam int IFS_PIN_LSB = 2;

    // detect pins idle high, the other pins idle low
    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b00011;

    typedef enum logic [ADDR_W-1:0] {
        RA_IFSTAT = 3'd0,
        RA_LSTAT  = 3'd1,
        RA_LEN    = 3'd2,
        RA_GSTAT  = 3'd3,
        RA_GSTEN  = 3'd4,
        RA_GSGEN  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/cfh_pin_sync.sv
module cfh_pin_sync #(
    parameter int              W      = 5,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_comb stage_d[k] = d_i;
            end else begin : g_next
                always_comb stage_d[k] = stage_q[k-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[k] <= RST;
                else        stage_q[k] <= stage_d[k];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfh_card_detect.sv
module cfh_card_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cd_n_sync_i,
    output logic       evt_o,
    output logic       inserted_o
);
    typedef struct packed {
        logic ins;
    } det_t;

    det_t det_d, det_q;
    logic ins_now;

    always_comb begin
        ins_now   = ~cd_n_sync_i[0] & ~cd_n_sync_i[1];
        det_d     = det_q;
        det_d.ins = ins_now;
        evt_o     = ins_now ^ det_q.ins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign inserted_o = det_q.ins;

    // R6: every event coincides with a toggle of the registered state
    p_detect_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (inserted_o == !$past(inserted_o)));
endmodule

// File: rtl/cfh_local_irq.sv
module cfh_local_irq #(
    parameter int             W    = 12,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic         en_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] en;
    } lcl_t;

    lcl_t st_d, st_q;
    logic [W-1:0] evt_m;

    always_comb begin
        evt_m = evt_i & IMPL;
        st_d  = st_q;
        if (clr_we_i) st_d.sts = st_q.sts & ~wdata_i;
        st_d.sts = st_d.sts | evt_m;          // event beats clear
        if (en_we_i)  st_d.en  = wdata_i & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.sts;
    assign enable_o = st_q.en;
    assign pend_o   = |(st_q.sts & st_q.en);

    // R4: an implemented event is never lost to a same-cycle clear
    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_m |=> ((status_o & $past(evt_m)) == $past(evt_m)));

    // R3: cleared bits without a matching event read zero afterwards
    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((status_o & $past(wdata_i & ~evt_m)) == '0));
endmodule

// File: rtl/cfh_global_irq.sv
module cfh_global_irq #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic         sten_we_i,
    input  logic         sgen_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic         sten_o,
    output logic         sgen_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] sts;
        logic         sten;
        logic         sgen;
    } glb_t;

    glb_t gl_d, gl_q;

    always_comb begin
        gl_d = gl_q;
        if (clr_we_i)  gl_d.sts  = gl_q.sts & ~wdata_i;
        gl_d.sts = gl_d.sts | (set_i & {W{gl_q.sten}});
        if (sten_we_i) gl_d.sten = wdata_i[0];
        if (sgen_we_i) gl_d.sgen = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gl_q <= '0;
        else        gl_q <= gl_d;
    end

    assign status_o = gl_q.sts;
    assign sten_o   = gl_q.sten;
    assign sgen_o   = gl_q.sgen;
    assign irq_o    = gl_q.sten & gl_q.sgen & (|gl_q.sts);

    // R5: a set request while status-enable is on is latched
    p_set_latches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sten_o && |set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R8: disabling the signal path silences the line
    p_sig_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sgen_we_i && !wdata_i[0]) |=> !irq_o);
endmodule

// File: rtl/cfh_irq_hub.sv
module cfh_irq_hub
    import cfh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LCL_W-1:0]  src_evt,
    input  logic              sib_evt,
    input  logic [1:0]        cd_n,
    input  logic              card_ack,
    input  logic              card_rdy,
    input  logic              card_iordy,
    output logic              irq_o
);
    logic [PIN_W-1:0] pin_raw, pin_s;
    logic             det_evt, inserted;
    logic [LCL_W-1:0] lcl_evt, lcl_sts, lcl_en;
    logic             lcl_pend;
    logic [GLB_W-1:0] glb_sts;
    logic             glb_sten, glb_sgen;
    logic             we_lstat, we_len, we_gstat, we_gsten, we_gsgen;
    logic             unused_bus;

    assign pin_raw    = {card_iordy, card_rdy, card_ack, cd_n};
    assign unused_bus = ^bus_wdata[DATA_W-1:LCL_W] ^ inserted;

    cfh_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_s)
    );

    cfh_card_detect u_det (
        .clk(clk), .rst_n(rst_n), .cd_n_sync_i(pin_s[1:0]),
        .evt_o(det_evt), .inserted_o(inserted)
    );

    always_comb begin
        lcl_evt    = src_evt;
        lcl_evt[0] = src_evt[0] | det_evt;
        we_lstat = bus_wr && (bus_addr == RA_LSTAT);
        we_len   = bus_wr && (bus_addr == RA_LEN);
        we_gstat = bus_wr && (bus_addr == RA_GSTAT);
        we_gsten = bus_wr && (bus_addr == RA_GSTEN);
        we_gsgen = bus_wr && (bus_addr == RA_GSGEN);
    end

    cfh_local_irq #(.W(LCL_W), .IMPL(LCL_IMPL)) u_lcl (
        .clk(clk), .rst_n(rst_n), .evt_i(lcl_evt),
        .clr_we_i(we_lstat), .en_we_i(we_len),
        .wdata_i(bus_wdata[LCL_W-1:0]),
        .status_o(lcl_sts), .enable_o(lcl_en), .pend_o(lcl_pend)
    );

    cfh_global_irq #(.W(GLB_W)) u_glb (
        .clk(clk), .rst_n(rst_n), .set_i({sib_evt, lcl_pend}),
        .clr_we_i(we_gstat), .sten_we_i(we_gsten), .sgen_we_i(we_gsgen),
        .wdata_i(bus_wdata[GLB_W-1:0]),
        .status_o(glb_sts), .sten_o(glb_sten), .sgen_o(glb_sgen),
        .irq_o(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_IFSTAT: bus_rdata[IFS_PIN_LSB +: PIN_W] = pin_s;
            RA_LSTAT:  bus_rdata[LCL_W-1:0] = lcl_sts;
            RA_LEN:    bus_rdata[LCL_W-1:0] = lcl_en;
            RA_GSTAT:  bus_rdata[GLB_W-1:0] = glb_sts;
            RA_GSTEN:  bus_rdata[0] = glb_sten;
            RA_GSGEN:  bus_rdata[0] = glb_sgen;
            default:   bus_rdata = '0;
        endcase
    end

    // R6: a detect event lands in local bit 0 at the next edge
    p_detect_reaches_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        det_evt |=> lcl_sts[0]);
endmodule

// File: tb/sim_cfh_irq_hub.sv
`timescale 1ns/1ps
module sim_cfh_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] src_evt = '0;
    logic        sib_evt = 1'b0;
    logic [1:0]  cd_n = 2'b11;
    logic        card_ack = 1'b0, card_rdy = 1'b0, card_iordy = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cfh_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .sib_evt(sib_evt), .cd_n(cd_n), .card_ack(card_ack),
        .card_rdy(card_rdy), .card_iordy(card_iordy), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_src(input logic [11:0] v);
        @(negedge clk); src_evt = v;
        @(negedge clk); src_evt = '0;
    endtask

    task automatic pulse_sib();
        @(negedge clk); sib_evt = 1'b1;
        @(negedge clk); sib_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and read map
        rd(3'd0, v); chk("R1 ifstat", v, 32'h0C);
        for (int a = 1; a < 8; a++) begin
            rd(a[2:0], v); chk("R1 reg zero", v, 0);
        end
        chk("R1 irq", {31'b0, irq_o}, 0);

        wr(3'd4, 1); wr(3'd5, 1);
        rd(3'd4, v); chk("R9 gsten", v, 1);
        rd(3'd5, v); chk("R9 gsgen", v, 1);

        // sweep every local bit through both levels
        for (int i = 0; i < 12; i++) begin
            logic impl;
            logic [31:0] bit_v;
            impl  = (i < 4) || (i >= 8);
            bit_v = impl ? (32'h1 << i) : 32'h0;
            wr(3'd2, 32'h1 << i);
            rd(3'd2, v); chk("R9 len readback", v, bit_v);
            pulse_src(12'h1 << i);
            rd(3'd1, v); chk("R2 latch", v, bit_v);
            chk("R8 irq not yet", {31'b0, irq_o}, 0);
            tick();
            rd(3'd3, v); chk("R5 global bit0", v, {31'b0, impl});
            chk("R8 irq level", {31'b0, irq_o}, {31'b0, impl});
            wr(3'd1, 32'hFFF);
            rd(3'd1, v); chk("R3 clear all", v, 0);
            wr(3'd3, 1);
            rd(3'd3, v); chk("R5 global clear", v, 0);
            chk("R8 irq drop", {31'b0, irq_o}, 0);
        end

        // disabled local bit never reaches global level
        wr(3'd2, 0);
        pulse_src(12'h200); tick();
        rd(3'd3, v); chk("R5 no enable", v, 0);
        wr(3'd1, 32'hFFF);

        // write back of the read value
        pulse_src(12'hFFF);
        rd(3'd1, v); chk("R2 all implemented", v, 32'hF0F);
        wr(3'd1, v);
        rd(3'd1, v); chk("R3 write back", v, 0);

        // partial clear
        pulse_src(12'h300);
        wr(3'd1, 32'h100);
        rd(3'd1, v); chk("R3 partial", v, 32'h200);
        wr(3'd1, 32'hFFF);

        // R4 same cycle event and clear
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 32'h400; bus_wr = 1'b1; src_evt = 12'h400;
        @(negedge clk);
        bus_wr = 1'b0; src_evt = '0;
        rd(3'd1, v); chk("R4 event wins", v, 32'h400);
        wr(3'd1, 32'hFFF);

        // R5 re-set while the cause persists
        wr(3'd2, 32'h800);
        pulse_src(12'h800); tick();
        wr(3'd3, 1);
        rd(3'd3, v); chk("R5 re-set", v, 1);
        wr(3'd1, 32'hFFF); wr(3'd3, 1);
        rd(3'd3, v); chk("R5 cleared", v, 0);
        wr(3'd2, 0);

        // R7 sibling and R8 signal gating
        pulse_sib();
        rd(3'd3, v); chk("R7 sibling", v, 2);
        chk("R8 irq sibling", {31'b0, irq_o}, 1);
        wr(3'd5, 0);
        chk("R8 sig off", {31'b0, irq_o}, 0);
        wr(3'd5, 1);
        chk("R8 sig on", {31'b0, irq_o}, 1);
        wr(3'd3, 2);
        rd(3'd3, v); chk("R7 clear", v, 0);

        // R10 status-enable off
        wr(3'd4, 0);
        pulse_sib();
        rd(3'd3, v); chk("R10 no latch", v, 0);
        chk("R10 irq", {31'b0, irq_o}, 0);
        wr(3'd4, 1);

        // R6 card detect timing and decode
        @(negedge clk); cd_n = 2'b00;
        tick(); tick();
        rd(3'd1, v); chk("R6 before third edge", v, 0);
        rd(3'd0, v); chk("R6 pins low", v, 0);
        tick();
        rd(3'd1, v); chk("R6 insert event", v, 1);
        wr(3'd1, 1);
        @(negedge clk); cd_n = 2'b01;
        tick(); tick(); tick();
        rd(3'd1, v); chk("R6 removal event", v, 1);
        wr(3'd1, 1);
        @(negedge clk); cd_n = 2'b11;
        repeat (4) tick();
        rd(3'd1, v); chk("R6 no change", v, 0);
        @(negedge clk); cd_n = 2'b10;
        repeat (4) tick();
        rd(3'd1, v); chk("R6 one pin low", v, 0);
        rd(3'd0, v); chk("R6 pin map", v, 32'h08);

        @(negedge clk); cd_n = 2'b11; card_ack = 1'b1; card_iordy = 1'b1;
        tick();
        rd(3'd0, v); chk("R6 lag", v, 32'h08);
        tick();
        rd(3'd0, v); chk("R6 status pins", v, 32'h5C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule